// File: doc/BRIEF.md
# Serial Memory Slave Command Engine

This block is the bus-facing front end of a byte-addressed serial memory that sits on a two-wire I2C bus as a slave. A fast system clock oversamples the clock line and the data line. The block finds START and STOP conditions in those samples and takes the first byte after a START as a control byte. That byte is matched against a fixed device code and against three strap inputs. The block then runs the command the master asks for and drives the data line through an open-drain enable.

A write command carries a two-byte word address and at most one data byte. The data byte goes out on a single-cycle write strobe to a memory port. A write controller behind that port reports its internal write cycle through a busy flag, and the block stays silent while that flag is high. A read command streams bytes out of the memory port starting at the internal address pointer. Random reads, current-address reads and sequential reads all use the same pointer. The pointer wraps across the whole array.

Top module: `serial_mem_slave`

## Requirements
- R1: A START (the data line falls while the clock line is high) restarts control-byte decode from any state, even in the middle of a byte. A half-received data byte is then discarded without a write, and any address already loaded is kept. A STOP (the data line rises while the clock line is high) returns the block to idle with the data line released.
- R2: In the control byte, bits 7:4 must be 1010, bits 3:1 must equal `strap_i[2:0]`, and bit 0 selects read (1) or write (0). On a match the slave pulls the data line low for the ninth clock. On a mismatch it gives no acknowledge, drives nothing and touches neither memory nor pointer until the next START or STOP.
- R3: While `mem_busy_i` is high, a control byte is not acknowledged, even when it matches. The rest of that transfer is ignored.
- R4: After a write control byte, the high address byte comes first and then the low byte, and both are acknowledged. Bit 7 of the high byte is ignored, so the pointer is loaded with the 15 bits {high[6:0], low[7:0]}.
- R5: The first data byte of a write is acknowledged. It produces exactly one write strobe to the loaded address with that byte. Any later byte in the same transfer gets no acknowledge and produces no write.
- R6: After a byte write, the pointer holds the written address plus one.
- R7: A read control byte with no new address returns the byte at the pointer, most significant bit first. The pointer then advances by one.
- R8: A write header with an address, followed by a repeated START and a read control byte, returns data starting at the address just loaded.
- R9: A master acknowledge after a read byte makes the slave send the byte at the next address. The pointer wraps from 0x7FFF to 0x0000.
- R10: After a master no-acknowledge, the slave keeps the data line released for all further clocks until the next START or STOP.
- R11: The data-line enable changes only while the synchronized clock line is low, never during a clock high phase.
- R12: After reset the data line is released and both memory strobes are low. A read strobe and a write strobe are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as received |
| sda_i | input | 1 | Bus data line as received |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| strap_i | input | 3 | Device select straps compared with control byte bits 3:1 |
| mem_busy_i | input | 1 | Write controller is running an internal write cycle |
| mem_addr | output | 15 | Word address for the current memory strobe |
| mem_rd_en | output | 1 | Single-cycle read strobe; data must be valid on the following cycle |
| mem_rd_data | input | 8 | Read data from the memory port |
| mem_wr_en | output | 1 | Single-cycle write strobe |
| mem_wr_data | output | 8 | Byte to write |

## Verification
The hardest case to reach from the ports is a START that lands in the middle of a data byte, after the address bytes have been accepted. To get there, the bench sends a full write header, clocks three loose data bits and then issues a repeated START with a read control byte. The returned byte must come from the address just loaded, and no write may appear. The pointer wrap needs a sequential read that starts two bytes below the top of the array and acknowledges across the boundary. Silence under busy and after a mismatch is checked on every clock by a monitor that flags any drive of the data line during windows the bench has declared quiet.

// File: rtl/sms_pkg.sv
package sms_pkg;
   // Transfer phase of the command engine.
   typedef enum logic [2:0] {
      ST_IDLE,   // ignoring traffic until START
      ST_CTRL,   // shifting the control byte
      ST_AHI,    // high address byte
      ST_ALO,    // low address byte
      ST_WDATA,  // the single data byte of a write
      ST_RDATA   // streaming read bytes out
   } sms_state_e;

   localparam int SMS_BYTE_W = 8;
   localparam int SMS_ACK_BIT = 8;  // bit count at which a byte is complete
endpackage

// File: rtl/sms_line_sync.sv
module sms_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_ev,
   output logic stop_ev
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("sms_line_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] scl_ff, sda_ff;
   logic              scl_q, sda_q;

   // Idle bus is high on both lines, so reset the chain to ones.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_ff <= '1;
         sda_ff <= '1;
         scl_q  <= 1'b1;
         sda_q  <= 1'b1;
      end else begin
         scl_ff <= {scl_ff[STAGES-2:0], scl_i};
         sda_ff <= {sda_ff[STAGES-2:0], sda_i};
         scl_q  <= scl_ff[STAGES-1];
         sda_q  <= sda_ff[STAGES-1];
      end
   end

   assign scl_s    = scl_ff[STAGES-1];
   assign sda_s    = sda_ff[STAGES-1];
   assign scl_rise = scl_s & ~scl_q;
   assign scl_fall = ~scl_s & scl_q;
   assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/sms_addr_ptr.sv
module sms_addr_ptr #(
   parameter int AW = 15
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] load_val,
   input  logic          inc,
   output logic [AW-1:0] ptr
);
   generate
      if (AW < 1) begin : g_bad_aw
         $error("sms_addr_ptr: AW must be positive");
      end
   endgenerate

   // Natural AW-bit overflow gives the full-array wrap.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    ptr <= '0;
      else if (load) ptr <= load_val;
      else if (inc)  ptr <= ptr + 1'b1;
   end
endmodule

// File: rtl/serial_mem_slave.sv
module serial_mem_slave
   import sms_pkg::*;
#(
   parameter int          AW          = 15,
   parameter int          SEL_W       = 3,
   parameter int          SYNC_STAGES = 2,
   parameter logic [6:0]  DEV_ID      = 7'b1010_000
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  scl_i,
   input  logic                  sda_i,
   output logic                  sda_oe,
   input  logic [SEL_W-1:0]      strap_i,
   input  logic                  mem_busy_i,
   output logic [AW-1:0]         mem_addr,
   output logic                  mem_rd_en,
   input  logic [SMS_BYTE_W-1:0] mem_rd_data,
   output logic                  mem_wr_en,
   output logic [SMS_BYTE_W-1:0] mem_wr_data
);
   localparam int AH_W = AW - SMS_BYTE_W;

   generate
      if (AW < SMS_BYTE_W + 1 || AW > 2 * SMS_BYTE_W) begin : g_bad_aw
         $error("serial_mem_slave: AW must lie in 9..16");
      end
      if (SEL_W < 1 || SEL_W > 6) begin : g_bad_sel
         $error("serial_mem_slave: SEL_W must lie in 1..6");
      end
   endgenerate

   logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;

   sms_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_i    (scl_i),
      .sda_i    (sda_i),
      .scl_s    (scl_s),
      .sda_s    (sda_s),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_ev (start_ev),
      .stop_ev  (stop_ev)
   );

   logic          ptr_load, ptr_inc;
   logic [AW-1:0] ptr_val, ptr;

   sms_addr_ptr #(.AW(AW)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ptr_load),
      .load_val (ptr_val),
      .inc      (ptr_inc),
      .ptr      (ptr)
   );

   sms_state_e            st;
   logic [SMS_BYTE_W-1:0] rx_sh, tx_sh;
   logic [3:0]            bitcnt;
   logic                  ack_ph, rw, more, rd_pend;
   logic [AH_W-1:0]       ahi;
   logic [2:0]            bidx;
   logic                  sel_hit, byte_end, ack_end, bit_fall;

   // Control byte match: device code, straps, and silence while busy.
   assign sel_hit  = (rx_sh[7:SEL_W+1] == DEV_ID[6:SEL_W]) &&
                     (rx_sh[SEL_W:1] == strap_i) && !mem_busy_i;
   assign byte_end = scl_fall && !ack_ph && (bitcnt == 4'(SMS_ACK_BIT)) && (st != ST_IDLE);
   assign ack_end  = scl_fall && ack_ph && (st != ST_IDLE);
   assign bit_fall = scl_fall && !ack_ph && (st == ST_RDATA) &&
                     (bitcnt != 4'd0) && (bitcnt < 4'(SMS_ACK_BIT));
   assign bidx     = 3'(4'd7 - bitcnt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st          <= ST_IDLE;
         rx_sh       <= '0;
         tx_sh       <= '0;
         bitcnt      <= '0;
         ack_ph      <= 1'b0;
         rw          <= 1'b0;
         more        <= 1'b0;
         rd_pend     <= 1'b0;
         ahi         <= '0;
         sda_oe      <= 1'b0;
         mem_addr    <= '0;
         mem_rd_en   <= 1'b0;
         mem_wr_en   <= 1'b0;
         mem_wr_data <= '0;
         ptr_load    <= 1'b0;
         ptr_inc     <= 1'b0;
         ptr_val     <= '0;
      end else begin
         mem_rd_en <= 1'b0;
         mem_wr_en <= 1'b0;
         ptr_load  <= 1'b0;
         ptr_inc   <= 1'b0;
         // Read data arrives one cycle after the strobe was seen by memory.
         rd_pend   <= mem_rd_en;
         if (rd_pend) tx_sh <= mem_rd_data;

         if (start_ev) begin
            st     <= ST_CTRL;
            bitcnt <= '0;
            ack_ph <= 1'b0;
            sda_oe <= 1'b0;
         end else if (stop_ev) begin
            st     <= ST_IDLE;
            ack_ph <= 1'b0;
            sda_oe <= 1'b0;
         end else if (scl_rise && st != ST_IDLE) begin
            if (ack_ph) begin
               if (st == ST_RDATA) begin
                  // Master acknowledge: fetch the next byte now.
                  more <= ~sda_s;
                  if (!sda_s) begin
                     mem_rd_en <= 1'b1;
                     mem_addr  <= ptr;
                  end
               end
            end else if (bitcnt < 4'(SMS_ACK_BIT)) begin
               rx_sh  <= {rx_sh[6:0], sda_s};
               bitcnt <= bitcnt + 4'd1;
            end
         end else if (byte_end) begin
            ack_ph <= 1'b1;
            case (st)
               ST_CTRL: begin
                  if (sel_hit) begin
                     sda_oe <= 1'b1;
                     rw     <= rx_sh[0];
                     if (rx_sh[0]) begin
                        mem_rd_en <= 1'b1;
                        mem_addr  <= ptr;
                     end
                  end else begin
                     st     <= ST_IDLE;
                     ack_ph <= 1'b0;
                  end
               end
               ST_AHI: begin
                  sda_oe <= 1'b1;
                  ahi    <= rx_sh[AH_W-1:0];
               end
               ST_ALO: begin
                  sda_oe   <= 1'b1;
                  ptr_load <= 1'b1;
                  ptr_val  <= {ahi, rx_sh};
               end
               ST_WDATA: begin
                  sda_oe      <= 1'b1;
                  mem_wr_en   <= 1'b1;
                  mem_addr    <= ptr;
                  mem_wr_data <= rx_sh;
                  ptr_inc     <= 1'b1;
               end
               ST_RDATA: begin
                  sda_oe  <= 1'b0;
                  ptr_inc <= 1'b1;
               end
               default: begin
                  st     <= ST_IDLE;
                  ack_ph <= 1'b0;
               end
            endcase
         end else if (ack_end) begin
            ack_ph <= 1'b0;
            bitcnt <= '0;
            case (st)
               ST_CTRL: begin
                  if (rw) begin
                     st     <= ST_RDATA;
                     sda_oe <= ~tx_sh[7];
                  end else begin
                     st     <= ST_AHI;
                     sda_oe <= 1'b0;
                  end
               end
               ST_AHI: begin
                  st     <= ST_ALO;
                  sda_oe <= 1'b0;
               end
               ST_ALO: begin
                  st     <= ST_WDATA;
                  sda_oe <= 1'b0;
               end
               ST_RDATA: begin
                  if (more) begin
                     sda_oe <= ~tx_sh[7];
                  end else begin
                     st     <= ST_IDLE;
                     sda_oe <= 1'b0;
                  end
               end
               default: begin
                  // A write takes one data byte; the rest is ignored.
                  st     <= ST_IDLE;
                  sda_oe <= 1'b0;
               end
            endcase
         end else if (bit_fall) begin
            sda_oe <= ~tx_sh[bidx];
         end
      end
   end
endmodule

// File: rtl/sms_checker.sv
module sms_checker
   import sms_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       scl_s,
   input logic       stop_ev,
   input sms_state_e st,
   input logic       sda_oe,
   input logic       mem_busy_i,
   input logic       mem_rd_en,
   input logic       mem_wr_en
);
   // R1: a STOP leaves the data line released.
   assert_release_after_stop_R1: assert property (@(posedge clk) disable iff (!rst_n)
      stop_ev |=> !sda_oe);

   // R2: while ignoring traffic nothing is driven and memory is untouched.
   assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && $past(st == ST_IDLE)) |-> (!sda_oe && !mem_wr_en && !mem_rd_en));

   // R3: a control byte acknowledge only when the write controller was idle.
   assert_busy_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(sda_oe) && st == ST_CTRL) |-> $past(!mem_busy_i));

   // R5: one write strobe per accepted data byte.
   assert_single_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_en |=> !mem_wr_en);

   // R11: the data-line enable is steady through a clock high phase.
   assert_steady_in_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_s && $past(scl_s)) |-> $stable(sda_oe));

   // R12: read and write strobes are exclusive.
   assert_strobe_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd_en && mem_wr_en));
endmodule

bind serial_mem_slave sms_checker u_sms_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .scl_s      (scl_s),
   .stop_ev    (stop_ev),
   .st         (st),
   .sda_oe     (sda_oe),
   .mem_busy_i (mem_busy_i),
   .mem_rd_en  (mem_rd_en),
   .mem_wr_en  (mem_wr_en)
);

// File: tb/tb_serial_mem_slave.sv
module tb_serial_mem_slave;
   localparam int T = 10;  // system clocks per quarter bus bit

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        scl_m = 1'b1, sda_m = 1'b1;
   logic        sda_line;
   logic        sda_oe;
   logic [2:0]  strap = 3'b101;
   logic        busy = 1'b0;
   logic [14:0] mem_addr;
   logic        mem_rd_en, mem_wr_en;
   logic [7:0]  rd_q = 8'h00;
   logic [7:0]  mem_wr_data;

   always #5 clk = ~clk;

   assign sda_line = sda_m & ~sda_oe;

   serial_mem_slave dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .scl_i       (scl_m),
      .sda_i       (sda_line),
      .sda_oe      (sda_oe),
      .strap_i     (strap),
      .mem_busy_i  (busy),
      .mem_addr    (mem_addr),
      .mem_rd_en   (mem_rd_en),
      .mem_rd_data (rd_q),
      .mem_wr_en   (mem_wr_en),
      .mem_wr_data (mem_wr_data)
   );

   int          n_tests = 0, n_fail = 0;
   bit          done = 1'b0, quiet = 1'b0;
   bit [7:0]    wmem [int];
   logic [22:0] wq [$];

   function automatic logic [7:0] model_rd(input logic [14:0] a);
      if (wmem.exists(int'(a))) return wmem[int'(a)];
      return a[7:0] ^ {1'b0, a[14:8]} ^ 8'h5A;
   endfunction

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Memory behind the port: read data valid the cycle after the strobe.
   always @(posedge clk) begin
      if (mem_rd_en) rd_q <= model_rd(mem_addr);
      if (mem_wr_en) wmem[int'(mem_addr)] = mem_wr_data;
   end

   // Per-clock reference checks on the bus and the memory port.
   logic scl_prev = 1'b1, oe_prev = 1'b0;
   always begin
      @(posedge clk);
      #1;
      if (rst_n) begin
         if (quiet && sda_oe)
            check(1'b0, "R2/R3/R10 drive in quiet window", 1, 0);
         if (scl_m && scl_prev && sda_oe != oe_prev)
            check(1'b0, "R11 enable changed with clock high", 32'(sda_oe), 32'(oe_prev));
         if (mem_wr_en && mem_rd_en)
            check(1'b0, "R12 both strobes", 1, 0);
         if (mem_wr_en) begin
            if (wq.size() == 0) check(1'b0, "R5 unexpected write", {mem_addr, mem_wr_data}, 0);
            else begin
               logic [22:0] e;
               e = wq.pop_front();
               check(e == {mem_addr, mem_wr_data}, "R5 write content", {mem_addr, mem_wr_data}, e);
            end
         end
      end
      scl_prev = scl_m;
      oe_prev  = sda_oe;
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start;
      sda_m = 1'b1; tick(T);
      scl_m = 1'b1; tick(T);
      sda_m = 1'b0; tick(T);
      scl_m = 1'b0; tick(T);
   endtask

   task automatic bus_stop;
      sda_m = 1'b0; tick(T);
      scl_m = 1'b1; tick(T);
      sda_m = 1'b1; tick(T);
   endtask

   task automatic clk_bit(input bit b, output bit s);
      sda_m = b;    tick(T);
      scl_m = 1'b1; tick(T);
      s = sda_line; tick(T);
      scl_m = 1'b0; tick(T);
   endtask

   task automatic send_byte(input logic [7:0] b, output bit ack);
      bit s;
      for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
      clk_bit(1'b1, s);
      ack = ~s;
   endtask

   task automatic recv_byte(input bit mack, output logic [7:0] d);
      bit s;
      for (int i = 7; i >= 0; i--) begin
         clk_bit(1'b1, s);
         d[i] = s;
      end
      clk_bit(~mack, s);
      sda_m = 1'b1;
   endtask

   // Write header; the high byte always carries a set bit 7 (R4 ignores it).
   task automatic set_addr(input logic [14:0] a);
      bit ack;
      bus_start;
      send_byte(8'hAA, ack);            check(ack, "R2 write control ack", 32'(ack), 1);
      send_byte({1'b1, a[14:8]}, ack);  check(ack, "R4 high address ack", 32'(ack), 1);
      send_byte(a[7:0], ack);           check(ack, "R4 low address ack", 32'(ack), 1);
   endtask

   initial begin
      bit          ack, s, all1;
      logic [7:0]  d;

      tick(5);
      rst_n = 1'b1;
      tick(3);
      check(!sda_oe && !mem_rd_en && !mem_wr_en, "R12 reset state",
            {sda_oe, mem_rd_en, mem_wr_en}, 0);

      // R4/R5: byte write to 0x1234 (high byte sent as 0x92)
      set_addr(15'h1234);
      wq.push_back({15'h1234, 8'hA7});
      send_byte(8'hA7, ack);   check(ack, "R5 data ack", 32'(ack), 1);
      bus_stop; tick(5);
      check(wq.size() == 0, "R5 write issued", wq.size(), 0);

      // R3: busy write controller silences the slave
      busy = 1'b1; quiet = 1'b1;
      bus_start;
      send_byte(8'hAA, ack);   check(!ack, "R3 write control under busy", 32'(ack), 0);
      send_byte(8'h00, ack);   check(!ack, "R3 following byte under busy", 32'(ack), 0);
      bus_start;
      send_byte(8'hAB, ack);   check(!ack, "R3 read control under busy", 32'(ack), 0);
      bus_stop;
      quiet = 1'b0; busy = 1'b0;

      // R6/R7: current-address reads after the write
      bus_start;
      send_byte(8'hAB, ack);   check(ack, "R7 read control ack", 32'(ack), 1);
      recv_byte(1'b0, d); bus_stop;
      check(d == model_rd(15'h1235), "R6 pointer after write", d, model_rd(15'h1235));
      bus_start; send_byte(8'hAB, ack); recv_byte(1'b0, d); bus_stop;
      check(d == model_rd(15'h1236), "R7 pointer advance", d, model_rd(15'h1236));

      // R8: random read returns the written byte
      set_addr(15'h1234);
      bus_start; send_byte(8'hAB, ack); recv_byte(1'b0, d); bus_stop;
      check(d == 8'hA7, "R8 random read", d, 8'hA7);

      // R9: sequential read across the top of the array
      set_addr(15'h7FFE);
      bus_start; send_byte(8'hAB, ack);
      recv_byte(1'b1, d); check(d == model_rd(15'h7FFE), "R9 seq byte 0", d, model_rd(15'h7FFE));
      recv_byte(1'b1, d); check(d == model_rd(15'h7FFF), "R9 seq byte 1", d, model_rd(15'h7FFF));
      recv_byte(1'b0, d); check(d == model_rd(15'h0000), "R9 wrap to zero", d, model_rd(15'h0000));
      bus_stop;

      // R10: after a master no-acknowledge the line stays released
      bus_start; send_byte(8'hAB, ack); recv_byte(1'b0, d);
      check(d == model_rd(15'h0001), "R9 pointer after wrap", d, model_rd(15'h0001));
      quiet = 1'b1; all1 = 1'b1;
      for (int i = 0; i < 9; i++) begin
         clk_bit(1'b1, s);
         all1 &= s;
      end
      check(all1, "R10 released after nack", 32'(all1), 1);
      bus_stop; quiet = 1'b0;

      // R2: strap mismatch and code mismatch are ignored
      quiet = 1'b1;
      bus_start;
      send_byte(8'hA8, ack);   check(!ack, "R2 strap mismatch", 32'(ack), 0);
      send_byte(8'h00, ack);   check(!ack, "R2 ignored byte", 32'(ack), 0);
      send_byte(8'h55, ack);
      bus_stop;
      bus_start;
      send_byte(8'hBA, ack);   check(!ack, "R2 code mismatch", 32'(ack), 0);
      bus_stop;
      quiet = 1'b0;
      bus_start; send_byte(8'hAB, ack); recv_byte(1'b0, d); bus_stop;
      check(d == model_rd(15'h0002), "R2 pointer untouched", d, model_rd(15'h0002));

      // R5: a second data byte is refused
      set_addr(15'h0100);
      wq.push_back({15'h0100, 8'h3C});
      send_byte(8'h3C, ack);   check(ack, "R5 first data ack", 32'(ack), 1);
      send_byte(8'h55, ack);   check(!ack, "R5 second data refused", 32'(ack), 0);
      bus_stop; tick(5);
      check(wq.size() == 0, "R5 single write", wq.size(), 0);
      bus_start; send_byte(8'hAB, ack); recv_byte(1'b0, d); bus_stop;
      check(d == model_rd(15'h0101), "R6 pointer after second write", d, model_rd(15'h0101));
      set_addr(15'h0100);
      bus_start; send_byte(8'hAB, ack);
      recv_byte(1'b1, d); check(d == 8'h3C, "R5 stored byte", d, 8'h3C);
      recv_byte(1'b0, d); check(d == model_rd(15'h0101), "R5 neighbour untouched", d, model_rd(15'h0101));
      bus_stop;

      // R1: START in the middle of a data byte
      set_addr(15'h0200);
      clk_bit(1'b1, s); clk_bit(1'b0, s); clk_bit(1'b1, s);
      bus_start;
      send_byte(8'hAB, ack);   check(ack, "R1 restart decode", 32'(ack), 1);
      recv_byte(1'b0, d); bus_stop;
      check(d == model_rd(15'h0200), "R1 address kept after abort", d, model_rd(15'h0200));
      check(!wmem.exists(32'h200), "R1 no write from partial byte", 0, 0);
      check(!sda_oe, "R1 released after stop", 32'(sda_oe), 0);

      tick(10);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule